// File: doc/BRIEF.md
# Raster Timing Generator

This block walks a raster one pixel per clock and produces the horizontal and vertical sync pulses, a display-enable strobe, the pixel column and row of the current active pixel, and a flag that tells software whether the beam is in vertical retrace. Each line and each frame runs in a fixed order: active region, front porch, sync pulse, back porch. Every timing quantity comes from a small register set, written through a one-cycle write port of address, data and strobe.

Horizontal blanking, front porch and sync width are given in 8-pixel units, each as the unit count minus one. Vertical quantities are given in lines, also minus one. Active width and active height are each given as the count minus one. Writes land in a pending copy of the register set, and that copy moves into the live set only when the raster wraps from the last pixel of a frame to the first. A frame therefore never mixes two timings. A blank bit keeps display-enable low while the sync pulses keep running. One polarity bit per axis selects whether the sync pulse is driven high or low.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held, de and vblank_status are 0, x and y are 0, and hsync and vsync sit at their inactive level for the reset polarity (high when the reset polarity bit is 0).
- R2: A line lasts A + 8·(HB+1) clocks, where A = (address 0x01 field [10:0]) + 1 and HB = address 0x02 field [5:0]. Pixels 0 to A−1 of each active line give de high with x equal to the pixel index. The first pixel after reset release appears on the outputs one clock after the first rising edge.
- R3: A frame lasts V + (VB+1) lines, where V = (address 0x05 field [10:0]) + 1 and VB = address 0x06 field [7:0]. Lines 0 to V−1 are active, and y equals the line index while de is high.
- R4: The horizontal sync pulse starts at pixel A + 8·(HF+1) and lasts 8·(HS+1) pixels. HF is address 0x03 field [4:0] and HS is address 0x04 field [3:0].
- R5: The vertical sync pulse covers lines V + VF + 1 through V + VF + VS + 1. VF is address 0x07 field [7:0] and VS is address 0x08 field [3:0]. vsync changes only at the first pixel of a line.
- R6: Bit 7 of address 0x04 (horizontal) and bit 7 of address 0x08 (vertical) set the sync sense. A value of 1 drives the pulse high and leaves the line low otherwise. A value of 0 does the reverse.
- R7: Bit 0 of address 0x00 set to 1 forces de low for whole frames. hsync, vsync and vblank_status keep their normal timing while blanked.
- R8: vblank_status is 1 on every pixel of lines V and above, and 0 on active lines.
- R9: A write takes effect from the first pixel of the frame after the one in which it lands. The rest of the current frame keeps the old timing.
- R10: Writes to any address other than 0x00 to 0x08 change no output timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register address for a write |
| reg_wdata | input | 16 | Register write data |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| hsync | output | 1 | Horizontal sync, sense set by register |
| vsync | output | 1 | Vertical sync, sense set by register |
| de | output | 1 | Display enable |
| x | output | 11 | Pixel column, valid while de is high |
| y | output | 11 | Pixel row, valid while de is high |
| vblank_status | output | 1 | 1 while in vertical non-display lines |

## Verification
Each output is registered once behind the raster counters, so a raster position shows up on the pins one clock after the counter holds it. The first pixel of a frame therefore appears one clock after the first edge that follows reset release. A register write only alters the pixels of the frame that starts after the write edge. The bench builds a whole frame of expected values the moment the previous frame's last pixel has been compared. It uses the pending configuration as it stands at that moment, and a monitor compares one queued item per clock on the falling edge. Every write is issued in the middle of a frame, far from a wrap edge, so the frame in which a change is due is never ambiguous.

// File: rtl/raster_timing_pkg.sv
package raster_timing_pkg;

   // coordinate width of the x / y outputs and of the active-size fields
   localparam int COORD_W   = 11;
   // internal raster counter width: active size plus blanking must fit
   localparam int CNT_W     = COORD_W + 1;
   // horizontal quantities are counted in units of 2**UNIT_LOG2 pixels
   localparam int UNIT_LOG2 = 3;
   // field widths of the timing registers
   localparam int HBLK_W    = 6;
   localparam int HFP_W     = 5;
   localparam int HSW_W     = 4;
   localparam int VBLK_W    = 8;
   localparam int VFP_W     = 8;
   localparam int VSW_W     = 4;
   // bit of the sync-width registers that selects the pulse sense
   localparam int POL_BIT   = 7;
   localparam int ADDR_W    = 8;
   localparam int DATA_W    = 16;

   typedef enum logic [ADDR_W-1:0] {
      RT_CTRL   = 8'h00,
      RT_HACT   = 8'h01,
      RT_HBLANK = 8'h02,
      RT_HFRONT = 8'h03,
      RT_HSYNC  = 8'h04,
      RT_VACT   = 8'h05,
      RT_VBLANK = 8'h06,
      RT_VFRONT = 8'h07,
      RT_VSYNC  = 8'h08
   } rt_addr_e;

   typedef struct packed {
      logic               blank;
      logic [COORD_W-1:0] hact_m1;
      logic [HBLK_W-1:0]  hblk_m1;
      logic [HFP_W-1:0]   hfp_m1;
      logic [HSW_W-1:0]   hsw_m1;
      logic               hpol;
      logic [COORD_W-1:0] vact_m1;
      logic [VBLK_W-1:0]  vblk_m1;
      logic [VFP_W-1:0]   vfp_m1;
      logic [VSW_W-1:0]   vsw_m1;
      logic               vpol;
   } rt_cfg_t;

endpackage

// File: rtl/raster_timing_regs.sv
module raster_timing_regs
   import raster_timing_pkg::*;
#(
   parameter rt_cfg_t RESET_CFG = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              frame_load,
   output rt_cfg_t           cfg_live
);

   rt_cfg_t cfg_pend;

   if (POL_BIT <= HSW_W - 1 || POL_BIT <= VSW_W - 1) begin : g_bad_pol
      $error("sync sense bit overlaps the sync width field");
   end
   if (COORD_W > DATA_W || VBLK_W > DATA_W || VFP_W > DATA_W) begin : g_bad_data
      $error("register field wider than the write data");
   end

   // pending copy: written by the port at any time
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_pend <= RESET_CFG;
      end else if (wr_en) begin
         case (wr_addr)
            RT_CTRL:   cfg_pend.blank   <= wr_data[0];
            RT_HACT:   cfg_pend.hact_m1 <= wr_data[COORD_W-1:0];
            RT_HBLANK: cfg_pend.hblk_m1 <= wr_data[HBLK_W-1:0];
            RT_HFRONT: cfg_pend.hfp_m1  <= wr_data[HFP_W-1:0];
            RT_HSYNC: begin
               cfg_pend.hsw_m1 <= wr_data[HSW_W-1:0];
               cfg_pend.hpol   <= wr_data[POL_BIT];
            end
            RT_VACT:   cfg_pend.vact_m1 <= wr_data[COORD_W-1:0];
            RT_VBLANK: cfg_pend.vblk_m1 <= wr_data[VBLK_W-1:0];
            RT_VFRONT: cfg_pend.vfp_m1  <= wr_data[VFP_W-1:0];
            RT_VSYNC: begin
               cfg_pend.vsw_m1 <= wr_data[VSW_W-1:0];
               cfg_pend.vpol   <= wr_data[POL_BIT];
            end
            default: ;
         endcase
      end
   end

   // live copy: moves over only on the wrap to the first pixel of a frame
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_live <= RESET_CFG;
      end else if (frame_load) begin
         cfg_live <= cfg_pend;
      end
   end

endmodule

// File: rtl/raster_axis_counter.sv
module raster_axis_counter #(
   parameter int W = 12
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic [W-1:0] len_active,
   input  logic [W-1:0] len_total,
   input  logic [W-1:0] sync_from,
   input  logic [W-1:0] sync_to,
   output logic [W-1:0] cnt,
   output logic         last,
   output logic         in_active,
   output logic         in_sync
);

   if (W < 4) begin : g_bad_w
      $error("axis counter too narrow");
   end

   assign last      = (cnt == len_total - W'(1));
   assign in_active = (cnt < len_active);
   assign in_sync   = (cnt >= sync_from) && (cnt < sync_to);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= last ? '0 : cnt + W'(1);
      end
   end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import raster_timing_pkg::*;
#(
   parameter int DEF_HACT_M1 = 639,
   parameter int DEF_HBLK_M1 = 19,
   parameter int DEF_HFP_M1  = 1,
   parameter int DEF_HSW_M1  = 11,
   parameter bit DEF_HPOL    = 1'b0,
   parameter int DEF_VACT_M1 = 479,
   parameter int DEF_VBLK_M1 = 44,
   parameter int DEF_VFP_M1  = 9,
   parameter int DEF_VSW_M1  = 1,
   parameter bit DEF_VPOL    = 1'b0,
   parameter bit REG_OUTPUTS = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [7:0]         reg_addr,
   input  logic [15:0]        reg_wdata,
   input  logic               reg_wr,
   output logic               hsync,
   output logic               vsync,
   output logic               de,
   output logic [COORD_W-1:0] x,
   output logic [COORD_W-1:0] y,
   output logic               vblank_status
);

   localparam rt_cfg_t RST_CFG = '{
      blank:   1'b0,
      hact_m1: COORD_W'(DEF_HACT_M1),
      hblk_m1: HBLK_W'(DEF_HBLK_M1),
      hfp_m1:  HFP_W'(DEF_HFP_M1),
      hsw_m1:  HSW_W'(DEF_HSW_M1),
      hpol:    DEF_HPOL,
      vact_m1: COORD_W'(DEF_VACT_M1),
      vblk_m1: VBLK_W'(DEF_VBLK_M1),
      vfp_m1:  VFP_W'(DEF_VFP_M1),
      vsw_m1:  VSW_W'(DEF_VSW_M1),
      vpol:    DEF_VPOL
   };

   if (DEF_HACT_M1 < 0 || DEF_HACT_M1 >= (1 << COORD_W) ||
       DEF_VACT_M1 < 0 || DEF_VACT_M1 >= (1 << COORD_W)) begin : g_bad_act
      $error("default active size out of field range");
   end
   if (DEF_HBLK_M1 >= (1 << HBLK_W) || DEF_HFP_M1 >= (1 << HFP_W) ||
       DEF_HSW_M1 >= (1 << HSW_W)) begin : g_bad_h
      $error("default horizontal timing out of field range");
   end
   if (DEF_VBLK_M1 >= (1 << VBLK_W) || DEF_VFP_M1 >= (1 << VFP_W) ||
       DEF_VSW_M1 >= (1 << VSW_W)) begin : g_bad_v
      $error("default vertical timing out of field range");
   end
   if (CNT_W <= COORD_W) begin : g_bad_cnt
      $error("raster counter must be wider than a coordinate");
   end

   rt_cfg_t          cfg_live;
   logic             frame_load;
   logic [CNT_W-1:0] h_act, h_tot, h_ss, h_se;
   logic [CNT_W-1:0] v_act, v_tot, v_ss, v_se;
   logic [CNT_W-1:0] h_cnt, v_cnt;
   logic             h_last, v_last, h_act_on, v_act_on, h_sync_on, v_sync_on;

   raster_timing_regs #(.RESET_CFG(RST_CFG)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .wr_addr    (reg_addr),
      .wr_data    (reg_wdata),
      .frame_load (frame_load),
      .cfg_live   (cfg_live)
   );

   // lengths and pulse edges derived from the live register set
   always_comb begin
      h_act = CNT_W'(cfg_live.hact_m1) + CNT_W'(1);
      h_tot = h_act + ((CNT_W'(cfg_live.hblk_m1) + CNT_W'(1)) << UNIT_LOG2);
      h_ss  = h_act + ((CNT_W'(cfg_live.hfp_m1)  + CNT_W'(1)) << UNIT_LOG2);
      h_se  = h_ss  + ((CNT_W'(cfg_live.hsw_m1)  + CNT_W'(1)) << UNIT_LOG2);
      v_act = CNT_W'(cfg_live.vact_m1) + CNT_W'(1);
      v_tot = v_act + CNT_W'(cfg_live.vblk_m1) + CNT_W'(1);
      v_ss  = v_act + CNT_W'(cfg_live.vfp_m1)  + CNT_W'(1);
      v_se  = v_ss  + CNT_W'(cfg_live.vsw_m1)  + CNT_W'(1);
   end

   raster_axis_counter #(.W(CNT_W)) u_hcnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (1'b1),
      .len_active (h_act),
      .len_total  (h_tot),
      .sync_from  (h_ss),
      .sync_to    (h_se),
      .cnt        (h_cnt),
      .last       (h_last),
      .in_active  (h_act_on),
      .in_sync    (h_sync_on)
   );

   raster_axis_counter #(.W(CNT_W)) u_vcnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (h_last),
      .len_active (v_act),
      .len_total  (v_tot),
      .sync_from  (v_ss),
      .sync_to    (v_se),
      .cnt        (v_cnt),
      .last       (v_last),
      .in_active  (v_act_on),
      .in_sync    (v_sync_on)
   );

   assign frame_load = h_last & v_last;

   logic               de_n, hs_n, vs_n, vb_n;
   logic [COORD_W-1:0] x_n, y_n;

   always_comb begin
      de_n = h_act_on & v_act_on & ~cfg_live.blank;
      hs_n = cfg_live.hpol ? h_sync_on : ~h_sync_on;
      vs_n = cfg_live.vpol ? v_sync_on : ~v_sync_on;
      vb_n = ~v_act_on;
      x_n  = h_cnt[COORD_W-1:0];
      y_n  = v_cnt[COORD_W-1:0];
   end

   if (REG_OUTPUTS) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            de            <= 1'b0;
            hsync         <= ~DEF_HPOL;
            vsync         <= ~DEF_VPOL;
            vblank_status <= 1'b0;
            x             <= '0;
            y             <= '0;
         end else begin
            de            <= de_n;
            hsync         <= hs_n;
            vsync         <= vs_n;
            vblank_status <= vb_n;
            x             <= x_n;
            y             <= y_n;
         end
      end
   end else begin : g_out_comb
      always_comb begin
         de            = de_n;
         hsync         = hs_n;
         vsync         = vs_n;
         vblank_status = vb_n;
         x             = x_n;
         y             = y_n;
      end
   end

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
   import raster_timing_pkg::*;
#(
   parameter int OUT_LAT = 1
)(
   input logic               clk,
   input logic               rst_n,
   input logic               de,
   input logic               vsync,
   input logic [COORD_W-1:0] x,
   input logic [COORD_W-1:0] y,
   input logic               blank_live,
   input rt_cfg_t            cfg_live,
   input logic               frame_load,
   input logic [CNT_W-1:0]   h_pos
);

   // R2: consecutive enabled pixels step the column by one
   a_r2_x_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (de && $past(de)) |-> (x == $past(x) + COORD_W'(1)));

   // R3: the row holds through a run of enabled pixels
   a_r3_y_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (de && $past(de)) |-> (y == $past(y)));

   // R5: vsync moves only when the first pixel of a line reaches the pins
   a_r5_vsync_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vsync) |-> (h_pos == CNT_W'(OUT_LAT)));

   // R9: the live timing set changes only on a frame wrap
   a_r9_live_at_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_live) |-> $past(frame_load));

   if (OUT_LAT != 0) begin : g_lat
      // R7: blanking reaches the pins one clock later
      a_r7_blank_forces_de_low: assert property (@(posedge clk) disable iff (!rst_n)
         blank_live |=> !de);
   end else begin : g_nolat
      // R7: blanking acts on the pins at once
      a_r7_blank_forces_de_low: assert property (@(posedge clk) disable iff (!rst_n)
         blank_live |-> !de);
   end

endmodule

bind raster_timing_gen raster_timing_chk #(.OUT_LAT(int'(REG_OUTPUTS))) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .de         (de),
   .vsync      (vsync),
   .x          (x),
   .y          (y),
   .blank_live (cfg_live.blank),
   .cfg_live   (cfg_live),
   .frame_load (frame_load),
   .h_pos      (h_cnt)
);

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic        reg_wr = 1'b0;
   logic        hsync, vsync, de, vblank_status;
   logic [10:0] x, y;

   always #5 clk = ~clk;

   raster_timing_gen #(
      .DEF_HACT_M1(15), .DEF_HBLK_M1(1), .DEF_HFP_M1(0), .DEF_HSW_M1(0), .DEF_HPOL(1'b0),
      .DEF_VACT_M1(3),  .DEF_VBLK_M1(3), .DEF_VFP_M1(0), .DEF_VSW_M1(1), .DEF_VPOL(1'b0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
      .hsync(hsync), .vsync(vsync), .de(de), .x(x), .y(y), .vblank_status(vblank_status)
   );

   typedef struct {
      int ha, hb, hf, hs, hp, va, vb, vf, vs, vp, blank;
   } mcfg_t;

   typedef struct {
      bit de, hs, vs, vb;
      int x, y;
   } exp_t;

   mcfg_t pend = '{ha:15, hb:1, hf:0, hs:0, hp:0, va:3, vb:3, vf:0, vs:1, vp:0, blank:0};
   exp_t  exp_q[$];
   int    n_cmp = 0;
   int    n_bad = 0;
   int    frames = 0;
   int    pos = 0;
   bit    run = 1'b0;
   bit    done = 1'b0;
   string ctx = "R2 reset timing";

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic check(string tag, string what, int got, int want);
      n_cmp++;
      if (got != want) begin
         n_bad++;
         $display("FAIL %s [%s] %s: actual %0d expected %0d (frame %0d pixel %0d)",
                  tag, ctx, what, got, want, frames, pos);
      end
   endtask

   // scoreboard producer: one whole frame from the configuration due at the wrap
   task automatic push_frame();
      mcfg_t c;
      int hact, htot, hss, hse, vact, vtot, vss, vse;
      c    = pend;
      hact = c.ha + 1;
      htot = hact + 8 * (c.hb + 1);
      hss  = hact + 8 * (c.hf + 1);
      hse  = hss + 8 * (c.hs + 1);
      vact = c.va + 1;
      vtot = vact + c.vb + 1;
      vss  = vact + c.vf + 1;
      vse  = vss + c.vs + 1;
      for (int v = 0; v < vtot; v++) begin
         for (int h = 0; h < htot; h++) begin
            exp_t e;
            e.de = (h < hact) && (v < vact) && (c.blank == 0);
            e.hs = ((h >= hss) && (h < hse)) ? (c.hp != 0) : (c.hp == 0);
            e.vs = ((v >= vss) && (v < vse)) ? (c.vp != 0) : (c.vp == 0);
            e.vb = (v >= vact);
            e.x  = h;
            e.y  = v;
            exp_q.push_back(e);
         end
      end
   endtask

   // scoreboard consumer: one item per clock, sampled on the falling edge
   initial begin
      exp_t e;
      wait (run);
      forever begin
         @(negedge clk);
         if (exp_q.size() == 0) begin
            push_frame();
            frames++;
            pos = 0;
         end
         e = exp_q.pop_front();
         check("R2/R3/R7", "de", int'(de), int'(e.de));
         check("R4/R6", "hsync", int'(hsync), int'(e.hs));
         check("R5/R6", "vsync", int'(vsync), int'(e.vs));
         check("R8", "vblank_status", int'(vblank_status), int'(e.vb));
         if (e.de) begin
            check("R2", "x", int'(x), e.x);
            check("R3", "y", int'(y), e.y);
         end
         pos++;
      end
   end

   // register write, with the model's own decode of the map
   task automatic wr(int a, int d);
      reg_addr  = 8'(a);
      reg_wdata = 16'(d);
      reg_wr    = 1'b1;
      case (a)
         0: pend.blank = d & 1;
         1: pend.ha = d & 16'h7ff;
         2: pend.hb = d & 16'h3f;
         3: pend.hf = d & 16'h1f;
         4: begin pend.hs = d & 16'hf; pend.hp = (d >> 7) & 1; end
         5: pend.va = d & 16'h7ff;
         6: pend.vb = d & 16'hff;
         7: pend.vf = d & 16'hff;
         8: begin pend.vs = d & 16'hf; pend.vp = (d >> 7) & 1; end
         default: ;
      endcase
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      check("R1", "de in reset", int'(de), 0);
      check("R1", "vblank_status in reset", int'(vblank_status), 0);
      check("R1", "hsync in reset", int'(hsync), 1);
      check("R1", "vsync in reset", int'(vsync), 1);
      check("R1", "x in reset", int'(x), 0);
      check("R1", "y in reset", int'(y), 0);
      rst_n = 1'b1;
      run   = 1'b1;

      // mid frame 1: new timing with high-going syncs, plus stray writes
      wait (frames == 1 && pos == 100);
      ctx = "R9 R10 new timing from next frame";
      wr(1, 23); wr(2, 2); wr(3, 1); wr(4, 16'h0080); wr(5, 2);
      wr(6, 4);  wr(7, 1); wr(8, 16'h0080);
      wr(8'h20, 16'hffff); wr(8'h09, 16'hffff); wr(8'hff, 16'h0001);

      // mid frame 2: blank the display
      wait (frames == 2 && pos == 100);
      ctx = "R7 blanked frame";
      wr(0, 1);

      // mid frame 3: unblank, narrow active area, wide low-going hsync
      wait (frames == 3 && pos == 100);
      ctx = "R9 third timing set";
      wr(0, 0); wr(1, 7); wr(2, 3); wr(3, 0); wr(4, 1);
      wr(5, 5); wr(6, 1); wr(7, 0); wr(8, 0);

      wait (frames == 5 && pos == 10);
      run = 1'b0;
      report();
   end

endmodule